// File: doc/BRIEF.md
# Bunch-Interleaved Multichannel FIR Filter

This block runs one programmable FIR filter per bucket slot of a circulating beam, with all slots sharing one sample stream and one multiply-accumulate datapath. Each sample arrives tagged with its slot index. The filter's tap history for a slot holds one entry per revolution, so tap k of a slot is the sample that the same slot delivered k turns earlier. It is not k samples earlier in the stream. Every accepted sample produces one filtered output that carries the same slot index. The output feeds the correction DAC path of that plane.

One instance serves one plane. A full-size plane uses 324 slots and 32 taps, and the parameters scale to that size. The defaults are kept small so that elaboration stays light. Coefficients are shared by all slots of the instance. They are written through a simple write port into a pending bank. That bank becomes active all at once when the slot-0 sample of the next turn is accepted, so one turn never mixes two coefficient sets.

The datapath works on 18-bit signed words. Input samples are 14-bit two's complement and are sign-extended. All taps are multiplied in parallel, and the products are summed in a wide accumulator. The sum is rounded and saturated to the signed DAC width, and the result appears with a fixed two-cycle latency.

Top module: `bunch_fir`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid`, `out_slot` and `out_data` read 0. All history entries and both coefficient banks are cleared, so outputs stay 0 until coefficients are written and committed.
- R2: A sample is accepted when `in_valid` is 1 and `in_slot` is below NUM_SLOTS. Its result appears with `out_valid` = 1 exactly two clock edges after the edge that captured it, and `out_slot` equals its `in_slot`.
- R3: For a sample x accepted on slot s, the sum is acc = Σ c[k]·h_s[k] over k = 0..TAPS-1. Here h_s[0] is x, h_s[k] is the sample accepted on slot s k acceptances of that slot earlier, and c[k] is the active coefficient of tap k. Samples of other slots never enter this sum.
- R4: A slot's history advances only when a sample for that slot is accepted. Idle cycles (`in_valid` = 0) change no history.
- R5: A write (`coef_we` = 1) stores `coef_data` (signed 18-bit) into pending tap `coef_addr` (tap index k). Pending values become active when a slot-0 sample is accepted, and that slot-0 sample already uses them. A write in the same cycle as that slot-0 sample waits for the following slot-0 sample.
- R6: The output is (acc + 2^(SHIFT-1)) arithmetically shifted right by SHIFT bits, which rounds halves toward positive infinity. With SHIFT = 17 and c[0] = 65536 (all other taps 0), x = -3 gives -1 and x = 3 gives 2.
- R7: A rounded value above 2^(OUT_W-1)-1 is output as 2^(OUT_W-1)-1, and one below -2^(OUT_W-1) as -2^(OUT_W-1). `out_data` is two's complement.
- R8: A sample with `in_valid` = 1 and `in_slot` ≥ NUM_SLOTS is ignored. It produces no output, leaves every history unchanged and commits no coefficients.
- R9: While `out_valid` is 0, `out_data` and `out_slot` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_slot | input | SLOT_W | Bucket slot index of the sample |
| in_sample | input | IN_W | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | TAP_W | Tap index to write |
| coef_data | input | 18 | Signed coefficient value |
| out_valid | output | 1 | Filtered result present |
| out_slot | output | SLOT_W | Slot index of the result |
| out_data | output | OUT_W | Rounded, saturated signed result |

## Verification
The hardest case to reach from the ports is the boundary between coefficient sets. A write must land in exactly the cycle of a slot-0 sample, and the bench has to tell the turn that uses the old set from the turn that uses the new one. The stimulus schedules writes in three places: mid-turn, on the slot-0 cycle itself, and just before it. Deep cross-turn history is reached by running many full turns of random samples. Idle gaps and out-of-range slot indices are mixed into those turns, so that a wrong advance of the history changes later sums. Dedicated turns then drive odd half-scale values and full-scale values with large coefficients to reach the rounding and clipping corners.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int WORD_W = 18;
  typedef logic signed [WORD_W-1:0] word_t;
endpackage

// File: rtl/slot_history.sv
module slot_history
  import fir_pkg::*;
#(
  parameter int NUM_SLOTS = 12,
  parameter int TAPS      = 8,
  parameter int SLOT_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SLOT_W-1:0]            slot,
  input  word_t                        sample,
  output logic [TAPS-1:0][WORD_W-1:0] taps
);
  localparam int DEPTH = TAPS - 1;

  word_t               mem_q [NUM_SLOTS][DEPTH];
  word_t               row_d [DEPTH];
  logic [SLOT_W-1:0]   rd_idx;

  // keep the row index inside the array even for rejected slots
  always_comb begin
    rd_idx = ({1'b0, slot} < (SLOT_W+1)'(NUM_SLOTS)) ? slot : '0;
    taps[0]  = sample;
    row_d[0] = sample;
    for (int k = 1; k < TAPS; k++) taps[k] = mem_q[rd_idx][k-1];
    for (int d = 1; d < DEPTH; d++) row_d[d] = mem_q[rd_idx][d-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        for (int d = 0; d < DEPTH; d++) mem_q[s][d] <= '0;
    end else if (wr_en) begin
      for (int d = 0; d < DEPTH; d++) mem_q[rd_idx][d] <= row_d[d];
    end
  end
endmodule

// File: rtl/coef_bank.sv
module coef_bank
  import fir_pkg::*;
#(
  parameter int TAPS  = 8,
  parameter int TAP_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [TAP_W-1:0]             wr_addr,
  input  word_t                        wr_data,
  input  logic                         commit,
  output logic [TAPS-1:0][WORD_W-1:0] coefs
);
  word_t pend_q [TAPS];
  word_t act_q  [TAPS];

  // the committing sample already sees the pending set
  always_comb begin
    for (int k = 0; k < TAPS; k++) coefs[k] = commit ? pend_q[k] : act_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) begin
        pend_q[k] <= '0;
        act_q[k]  <= '0;
      end
    end else begin
      if (commit) begin
        for (int k = 0; k < TAPS; k++) act_q[k] <= pend_q[k];
      end
      if (wr_en && ({1'b0, wr_addr} < (TAP_W+1)'(TAPS))) pend_q[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/mac_pipe.sv
module mac_pipe
  import fir_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int TAP_W  = 3,
  parameter int SLOT_W = 4,
  parameter int OUT_W  = 14,
  parameter int SHIFT  = 17
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_vld,
  input  logic [SLOT_W-1:0]            in_slot,
  input  logic [TAPS-1:0][WORD_W-1:0] taps,
  input  logic [TAPS-1:0][WORD_W-1:0] coefs,
  output logic                         out_vld,
  output logic [SLOT_W-1:0]            out_slot,
  output logic [OUT_W-1:0]             out_data
);
  localparam int PROD_W = 2 * WORD_W;
  localparam int ACC_W  = PROD_W + TAP_W + 1;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'd1 << (OUT_W - 1)) - 64'd1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [PROD_W-1:0] prod_d [TAPS];
  logic signed [PROD_W-1:0] prod_q [TAPS];
  logic                     vld1_q;
  logic [SLOT_W-1:0]        slot1_q;
  logic signed [ACC_W-1:0]  acc, rnd, shr;
  logic [OUT_W-1:0]         res_d;

  for (genvar g = 0; g < TAPS; g++) begin : g_mul
    always_comb prod_d[g] = $signed(taps[g]) * $signed(coefs[g]);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + ACC_W'(prod_q[k]);
    rnd = acc + HALF;
    shr = rnd >>> SHIFT;
    if (shr > MAXV)      res_d = MAXV[OUT_W-1:0];
    else if (shr < MINV) res_d = MINV[OUT_W-1:0];
    else                 res_d = shr[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) prod_q[k] <= '0;
      vld1_q   <= 1'b0;
      slot1_q  <= '0;
      out_vld  <= 1'b0;
      out_slot <= '0;
      out_data <= '0;
    end else begin
      vld1_q  <= in_vld;
      out_vld <= vld1_q;
      if (in_vld) begin
        for (int k = 0; k < TAPS; k++) prod_q[k] <= prod_d[k];
        slot1_q <= in_slot;
      end
      if (vld1_q) begin
        out_slot <= slot1_q;
        out_data <= res_d;
      end
    end
  end
endmodule

// File: rtl/bunch_fir.sv
module bunch_fir
  import fir_pkg::*;
#(
  parameter int NUM_SLOTS = 12,
  parameter int TAPS      = 8,
  parameter int IN_W      = 14,
  parameter int OUT_W     = 14,
  parameter int SHIFT     = 17,
  parameter int SLOT_W    = $clog2(NUM_SLOTS + 1),
  parameter int TAP_W     = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [IN_W-1:0]   in_sample,
  input  logic              coef_we,
  input  logic [TAP_W-1:0]  coef_addr,
  input  logic [17:0]       coef_data,
  output logic              out_valid,
  output logic [SLOT_W-1:0] out_slot,
  output logic [OUT_W-1:0]  out_data
);
  logic                         accept;
  logic                         turn_start;
  word_t                        sample_w;
  logic [TAPS-1:0][WORD_W-1:0] tap_vec;
  logic [TAPS-1:0][WORD_W-1:0] coef_vec;

  always_comb begin
    accept     = in_valid && ({1'b0, in_slot} < (SLOT_W+1)'(NUM_SLOTS));
    turn_start = accept && (in_slot == '0);
    sample_w   = word_t'($signed(in_sample));
  end

  slot_history #(.NUM_SLOTS(NUM_SLOTS), .TAPS(TAPS), .SLOT_W(SLOT_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .slot(in_slot),
    .sample(sample_w), .taps(tap_vec)
  );

  coef_bank #(.TAPS(TAPS), .TAP_W(TAP_W)) u_coef (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_addr(coef_addr),
    .wr_data(word_t'(coef_data)), .commit(turn_start), .coefs(coef_vec)
  );

  mac_pipe #(.TAPS(TAPS), .TAP_W(TAP_W), .SLOT_W(SLOT_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_mac (
    .clk(clk), .rst_n(rst_n), .in_vld(accept), .in_slot(in_slot),
    .taps(tap_vec), .coefs(coef_vec),
    .out_vld(out_valid), .out_slot(out_slot), .out_data(out_data)
  );
endmodule

// File: rtl/bunch_fir_chk.sv
module bunch_fir_chk #(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 4,
  parameter int OUT_W     = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [SLOT_W-1:0] in_slot,
  input logic              out_valid,
  input logic [SLOT_W-1:0] out_slot,
  input logic [OUT_W-1:0]  out_data
);
  logic [1:0] cyc;
  logic       took;

  always_comb took = in_valid && ({1'b0, in_slot} < (SLOT_W+1)'(NUM_SLOTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R2
  out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (out_valid == $past(took, 2)));

  // R2
  slot_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && out_valid) |-> (out_slot == $past(in_slot, 2)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && !out_valid) |-> ($stable(out_data) && $stable(out_slot)));

  // R8
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_slot} < (SLOT_W+1)'(NUM_SLOTS)));
endmodule

bind bunch_fir bunch_fir_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot(in_slot),
  .out_valid(out_valid), .out_slot(out_slot), .out_data(out_data)
);

// File: tb/sim_bunch_fir.sv
module sim_bunch_fir;
  localparam int NS = 12;
  localparam int NT = 8;
  localparam int SW = 4;
  localparam int TW = 3;
  localparam int OW = 14;
  localparam int SH = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_slot = '0;
  logic [13:0]   in_sample = '0;
  logic          coef_we = 1'b0;
  logic [TW-1:0] coef_addr = '0;
  logic [17:0]   coef_data = '0;
  logic          out_valid;
  logic [SW-1:0] out_slot;
  logic [OW-1:0] out_data;

  always #2.5 clk = ~clk;

  bunch_fir #(.NUM_SLOTS(NS), .TAPS(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot(in_slot),
    .in_sample(in_sample), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .out_valid(out_valid), .out_slot(out_slot),
    .out_data(out_data)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model
  int  hist [NS][$];
  int  act [NT];
  int  pend [NT];
  bit  e1_v, e2_v;
  int  e1_s, e2_s, e1_d, e2_d;
  int  last_s = 0, last_d = 0;

  function automatic int round_clip(longint acc);
    longint r;
    r = (acc + (64'sd1 <<< (SH - 1))) >>> SH;
    if (r > 8191)  return 8191;
    if (r < -8192) return -8192;
    return int'(r);
  endfunction

  task automatic fail(string req, int act_v, int exp_v);
    bad++;
    $display("FAIL %s actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
  endtask

  task automatic compare();
    total++;
    if (out_valid !== e2_v) fail("R2 valid", int'(out_valid), int'(e2_v));
    else if (e2_v) begin
      if (int'(out_slot) != e2_s) fail("R2 slot", int'(out_slot), e2_s);
      else if (int'($signed(out_data)) != e2_d) fail(tag, int'($signed(out_data)), e2_d);
      last_s = e2_s;
      last_d = e2_d;
    end else begin
      if (int'($signed(out_data)) != last_d || int'(out_slot) != last_s)
        fail("R9 hold", int'($signed(out_data)), last_d);
    end
  endtask

  task automatic step(bit v, int s, int x, bit we = 0, int wa = 0, int wd = 0);
    longint acc;
    @(negedge clk);
    compare();
    e2_v = e1_v; e2_s = e1_s; e2_d = e1_d;
    in_valid  = v;
    in_slot   = SW'(s);
    in_sample = 14'(x);
    coef_we   = we;
    coef_addr = TW'(wa);
    coef_data = 18'(wd);
    e1_v = 0;
    if (v && s < NS) begin
      if (s == 0) act = pend;
      acc = longint'(act[0]) * x;
      for (int k = 1; k < NT; k++) acc += longint'(act[k]) * hist[s][k-1];
      hist[s].push_front(x);
      void'(hist[s].pop_back());
      e1_v = 1; e1_s = s; e1_d = round_clip(acc);
    end
    if (we) pend[wa] = wd;
  endtask

  function automatic int rnd_sample();
    return int'($urandom_range(16383)) - 8192;
  endfunction

  task automatic run_turns(int n, bit gaps);
    for (int t = 0; t < n; t++)
      for (int s = 0; s < NS; s++) begin
        if (gaps && ($urandom_range(3) == 0)) step(0, 0, 0);
        step(1, s, rnd_sample());
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) for (int k = 0; k < NT - 1; k++) hist[s].push_back(0);
    for (int k = 0; k < NT; k++) begin act[k] = 0; pend[k] = 0; end
    e1_v = 0; e2_v = 0; e1_s = 0; e2_s = 0; e1_d = 0; e2_d = 0;
    repeat (3) @(negedge clk);
    // R1: outputs zero in reset
    total++;
    if (out_valid !== 1'b0 || out_data !== '0 || out_slot !== '0)
      fail("R1 reset", int'(out_data), 0);
    rst_n = 1'b1;

    // R1: cleared coefficients give zero outputs
    tag = "R1";
    run_turns(1, 0);

    // R5: writes mid-turn only take effect at next slot 0
    tag = "R5";
    for (int s = 0; s < NS; s++) begin
      if (s >= 3 && s < 3 + NT) step(1, s, rnd_sample(), 1, s - 3, 20000 - 9000 * (s - 3));
      else step(1, s, rnd_sample());
    end
    run_turns(1, 0);

    // R3: cross-turn history with random data
    tag = "R3";
    run_turns(NT + 2, 0);

    // R4: idle gaps do not advance history
    tag = "R4";
    run_turns(6, 1);

    // R5: write in the same cycle as slot 0 waits a full turn
    tag = "R5";
    step(1, 0, rnd_sample(), 1, 0, -70000);
    for (int s = 1; s < NS; s++) step(1, s, rnd_sample());
    step(1, 0, rnd_sample(), 1, 1, 45000);
    for (int s = 1; s < NS; s++) step(1, s, rnd_sample());
    run_turns(2, 0);

    // R8: out-of-range slots ignored
    tag = "R8";
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < NS; s++) begin
        step(1, NS + (s % 4), 8000);
        step(1, s, rnd_sample());
      end

    // R6: rounding with half-scale unity tap
    tag = "R6";
    for (int k = 0; k < NT; k++) step(0, 0, 0, 1, k, (k == 0) ? 65536 : 0);
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < NS; s++) step(1, s, (s % 2) ? -3 - 2 * s : 3 + 2 * s);

    // R7: saturation both ways
    tag = "R7";
    for (int k = 0; k < NT; k++) step(0, 0, 0, 1, k, 131071);
    for (int t = 0; t < NT + 1; t++)
      for (int s = 0; s < NS; s++) step(1, s, (s < NS / 2) ? 8191 : -8192);
    for (int k = 0; k < NT; k++) step(0, 0, 0, 1, k, -131072);
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < NS; s++) step(1, s, (s < NS / 2) ? 8191 : -8192);

    repeat (4) step(0, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule